// File: doc/BRIEF.md
# Butterfly Switching Fabric with Per-Stage Exchange

The block moves up to N packets per cycle from N input lanes to N output lanes through a log2 N stage butterfly of 2x2 exchange elements. A packet offered on input lane `a` with destination `b` gets a routing tag `a ^ b`. Stage `k` pairs lanes whose indices differ only in bit `k`. At that stage, tag bit `k` picks between keeping the packet on its lane (0) and moving it to the partner lane (1). Only one path joins any source to any destination, and every packet crosses every stage, so all packets arrive the same number of cycles after they enter.

Each stage ends in a register, so a new set of packets (a wave) may enter on every cycle. Two valid packets may need the same output of one exchange element. In that case the packet coming from the element's lower-numbered lane wins and the other is dropped. The wave's conflict flag is then raised, and it travels with the wave so that it appears on the same cycle as that wave's surviving outputs. The fabric has no buffering, no retry and no multi-beat packets.

Top module: `bfly_fabric`

## Requirements
- R1: While reset is held and until the first wave arrives, `out_valid` is all zero and `out_conflict` is 0.
- R2: A packet offered on the inputs at a clock edge appears on the outputs exactly log2 N clock edges later, and not earlier.
- R3: A single valid packet on input lane `a` whose `in_dest` field (lane `j` uses bits `[j*log2N +: log2N]`) holds `b` comes out on output lane `b` only, with its data unchanged. This holds for every pair (a, b).
- R4: A full wave in which lane `j` is sent to `j ^ m`, for any constant `m`, delivers all N packets to their destinations with no conflict flag.
- R5: When two valid packets need the same exchange output, the packet from the element's lower lane wins and the other is lost. For two packets from lanes `a < b` sharing destination `d`, only lane `d` is valid, it carries the data from `a`, and `out_conflict` is 1 for that wave. With no collision in a stage, no packet is lost there.
- R6: No stage ever emits more valid packets than it received on the previous cycle.
- R7: Waves entered on consecutive cycles come out on consecutive cycles, each with its own data and its own conflict flag.
- R8: A lane with `in_valid` low has no effect on the outputs, whatever its data and destination are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Per-lane packet present |
| in_data | input | N*DW | Per-lane payload, lane j at [j*DW +: DW] |
| in_dest | input | N*log2N | Per-lane destination, lane j at [j*log2N +: log2N] |
| out_valid | output | N | Per-lane packet delivered |
| out_data | output | N*DW | Per-lane delivered payload |
| out_conflict | output | 1 | A packet of this wave was dropped in a collision |

## Verification
The assertions watch every stage on every cycle. A stage may not gain packets, it may not lose a packet unless a collision occurred there, every collision must set the wave's flag, and a flag once set must stay with its wave down the pipeline. Only the bench scenarios can show that packets reach the correct lane with the correct payload and the exact latency. The bench sweeps every source and destination pair, every XOR permutation, and every two-packet collision onto a shared destination, and checks which packet wins. It also checks back-to-back waves and inputs that carry no valid bit.

// File: rtl/bfly_fabric.sv
module bfly_fabric #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           in_valid,
  input  logic [N*DW-1:0]        in_data,
  input  logic [N*$clog2(N)-1:0] in_dest,
  output logic [N-1:0]           out_valid,
  output logic [N*DW-1:0]        out_data,
  output logic                   out_conflict
);
  localparam int S = $clog2(N);

  logic [N-1:0]  sv [S];
  logic [DW-1:0] sd [S][N];
  logic [S-1:0]  st [S][N];

  logic [N-1:0]  nv [S];
  logic [DW-1:0] nd [S][N];
  logic [S-1:0]  nt [S][N];
  logic [N-1:0]  hit [S];

  logic [N-1:0]  rv [S];
  logic [DW-1:0] rd [S][N];
  logic [S-1:0]  rt [S][N];
  logic [S-1:0]  rc;

  always_comb begin
    for (int j = 0; j < N; j++) begin
      sv[0][j] = in_valid[j];
      sd[0][j] = in_data[j*DW +: DW];
      st[0][j] = S'(j) ^ in_dest[j*S +: S];
    end
    for (int k = 1; k < S; k++) begin
      sv[k] = rv[k-1];
      sd[k] = rd[k-1];
      st[k] = rt[k-1];
    end
  end

  always_comb begin
    for (int k = 0; k < S; k++) begin
      for (int j = 0; j < N; j++) begin
        int   p;
        logic own_ok, par_ok, take_par;
        p        = j ^ (1 << k);
        own_ok   = sv[k][j] & ~st[k][j][k];
        par_ok   = sv[k][p] &  st[k][p][k];
        take_par = par_ok & (~own_ok | (p < j));
        nv[k][j]  = own_ok | par_ok;
        nd[k][j]  = take_par ? sd[k][p] : sd[k][j];
        nt[k][j]  = take_par ? st[k][p] : st[k][j];
        hit[k][j] = own_ok & par_ok;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < S; k++) rv[k] <= '0;
      rc <= '0;
    end else begin
      for (int k = 0; k < S; k++) begin
        rv[k] <= nv[k];
        rd[k] <= nd[k];
        rt[k] <= nt[k];
      end
      rc[0] <= |hit[0];
      for (int k = 1; k < S; k++) rc[k] <= rc[k-1] | (|hit[k]);
    end
  end

  always_comb
    for (int j = 0; j < N; j++) out_data[j*DW +: DW] = rd[S-1][j];

  assign out_valid    = rv[S-1];
  assign out_conflict = rc[S-1];

  for (genvar k = 0; k < S; k++) begin : g_chk
    // R6
    no_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rv[k]) <= $past($countones(sv[k])));
    // R5
    no_silent_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|hit[k]) |=> $countones(rv[k]) == $past($countones(sv[k])));
    // R5
    hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit[k]) |=> rc[k]);
    if (k > 0) begin : g_keep
      // R7
      flag_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rc[k-1] |=> rc[k]);
    end
  end
endmodule

// File: tb/bfly_fabric_tb.sv
module bfly_fabric_tb;
  localparam int N = 8;
  localparam int DW = 8;
  localparam int S = 3;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] in_valid;
  logic [N*DW-1:0] in_data;
  logic [N*S-1:0] in_dest;
  logic [N-1:0] out_valid;
  logic [N*DW-1:0] out_data;
  logic out_conflict;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfly_fabric #(.N(N), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_dest(in_dest), .out_valid(out_valid), .out_data(out_data),
    .out_conflict(out_conflict));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    in_valid = '0; in_data = '0; in_dest = '0;
  endtask

  task automatic put(input int lane, input int dst, input logic [DW-1:0] dat);
    in_valid[lane] = 1'b1;
    in_dest[lane*S +: S] = S'(dst);
    in_data[lane*DW +: DW] = dat;
  endtask

  function automatic logic [DW-1:0] pay(input int a, input int b);
    return DW'((a * 16 + b) ^ 8'h5a);
  endfunction

  task automatic launch_wait();
    @(negedge clk); clr();
    repeat (S-2) @(negedge clk);
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 valid in reset", out_valid, 0);
    chk(out_conflict == 0, "R1 conflict in reset", out_conflict, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(out_valid == 0 && out_conflict == 0, "R1 idle after reset", {out_conflict, out_valid}, 0);

    // R2 R3: every single source/destination pair
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) begin
        clr(); put(a, b, pay(a, b));
        launch_wait();
        chk(out_valid == 0, "R2 early output", out_valid, 0);
        @(negedge clk);
        chk(out_valid == N'(1 << b), "R3 lane", out_valid, N'(1 << b));
        chk(out_data[b*DW +: DW] == pay(a, b), "R3 data", out_data[b*DW +: DW], pay(a, b));
        chk(out_conflict == 0, "R3 no conflict", out_conflict, 0);
      end

    // R4: xor permutations, full load
    for (int m = 0; m < N; m++) begin
      clr();
      for (int j = 0; j < N; j++) put(j, j ^ m, pay(j, m));
      launch_wait(); @(negedge clk);
      chk(out_valid == '1, "R4 all delivered", out_valid, {N{1'b1}});
      chk(out_conflict == 0, "R4 no conflict", out_conflict, 0);
      for (int j = 0; j < N; j++)
        chk(out_data[(j^m)*DW +: DW] == pay(j, m), "R4 data", out_data[(j^m)*DW +: DW], pay(j, m));
    end

    // R5: two packets to one destination, lower lane wins
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        for (int d = 0; d < N; d++) begin
          clr(); put(a, d, pay(a, d)); put(b, d, pay(b, d));
          launch_wait(); @(negedge clk);
          chk(out_valid == N'(1 << d), "R5 lane", out_valid, N'(1 << d));
          chk(out_data[d*DW +: DW] == pay(a, d), "R5 winner", out_data[d*DW +: DW], pay(a, d));
          chk(out_conflict == 1, "R5 flag", out_conflict, 1);
        end

    // R8: invalid lanes with colliding destinations are ignored
    clr();
    for (int j = 0; j < N; j++) begin
      in_dest[j*S +: S] = 3'd6;
      in_data[j*DW +: DW] = 8'hee;
    end
    put(2, 6, 8'h3c);
    launch_wait(); @(negedge clk);
    chk(out_valid == 8'h40, "R8 lane", out_valid, 8'h40);
    chk(out_data[6*DW +: DW] == 8'h3c, "R8 data", out_data[6*DW +: DW], 8'h3c);
    chk(out_conflict == 0, "R8 no conflict", out_conflict, 0);

    // R7: three waves back to back (S == 3)
    @(negedge clk); clr(); put(1, 5, 8'h15);
    @(negedge clk); clr(); put(0, 3, 8'h03); put(1, 3, 8'h13);
    @(negedge clk); clr(); for (int j = 0; j < N; j++) put(j, j, pay(j, 7));
    @(negedge clk); clr();
    chk(out_valid == 8'h20 && out_data[5*DW +: DW] == 8'h15 && !out_conflict,
        "R7 wave0", {out_conflict, out_data[5*DW +: DW], out_valid}, {1'b0, 8'h15, 8'h20});
    @(negedge clk);
    chk(out_valid == 8'h08 && out_data[3*DW +: DW] == 8'h03 && out_conflict,
        "R7 wave1", {out_conflict, out_data[3*DW +: DW], out_valid}, {1'b1, 8'h03, 8'h08});
    @(negedge clk);
    chk(out_valid == 8'hff && !out_conflict, "R7 wave2", {out_conflict, out_valid}, {1'b0, 8'hff});
    for (int j = 0; j < N; j++)
      chk(out_data[j*DW +: DW] == pay(j, 7), "R7 wave2 data", out_data[j*DW +: DW], pay(j, 7));
    @(negedge clk);
    chk(out_valid == 0 && !out_conflict, "R7 drained", {out_conflict, out_valid}, 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule